// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a byte-wide parallel host bus and the embedded-operation engine of a 128K x 8 NOR-style flash model split into eight equal sectors. It watches qualified write cycles, each carrying a 17-bit address and an 8-bit data byte, and walks a state machine through the unlock handshakes that guard every non-read command. When a byte program, chip erase or sector erase sequence completes, it sends a one-cycle start pulse to the engine along with the operation code, the target address and the data byte.

The decoder also tells the read path which source to return: the memory array, the identifier and protection codes, or operation status. In identifier mode it produces the identifier byte for each read strobe. Any wrong cycle drops the decoder back to array reads. Writes that arrive while the engine reports busy have no effect.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and after writes made while rst_ni is low, rsel_o is 0 (array) and start_o is 0.
- R2: The sequence AAh@555h, 55h@2AAh, A0h@555h, then any data other than F0h at any address, raises start_o for exactly one cycle, in the cycle after the last write. With the pulse, op_o is 1 (program) and op_addr_o/op_data_o hold the address and data of that last write.
- R3: The sequence unlock, 80h@555h, unlock, 10h@555h raises start_o once, with op_o = 2 (chip erase).
- R4: The sequence unlock, 80h@555h, unlock, 30h@SA raises start_o once, with op_o = 3 (sector erase) and op_addr_o = SA. Bits 16:14 of SA select the sector.
- R5: Unlock followed by 90h@555h sets rsel_o to 1 (identifier) from the cycle after that write.
- R6: In identifier mode, a read strobe loads id_data_o on the next edge from address bits 7:0. Offset 00h gives 01h, offset 01h gives 20h, and any offset other than 00h, 01h or 02h gives 00h.
- R7: A read at offset 02h returns 01h if sect_prot_i[addr_i[16:14]] is 1 and 00h if it is 0.
- R8: F0h written at any address ends identifier mode. The form unlock then F0h@555h also ends it and leaves the decoder in array mode.
- R9: A wrong address or data value at any cycle of a sequence returns the decoder to array mode, so finishing the rest of that sequence starts nothing.
- R10: F0h written between the cycles of a sequence, including the fourth program cycle, cancels the sequence without a start.
- R11: While busy_i is high, or from a start until busy_i falls, writes are ignored and rsel_o is 2 (status). The engine raises busy_i in the cycle after start_o. When busy_i falls, rsel_o returns to 0.
- R12: Identifier mode persists through any number of reads and through any write whose data is not F0h.
- R13: Only address bits 11:0 are compared with 555h and 2AAh, so the upper bits are don't-care in unlock and command cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write cycle strobe |
| rd_i | input | 1 | Read cycle strobe |
| addr_i | input | 17 | Byte address for reads and writes |
| wdata_i | input | 8 | Write data |
| busy_i | input | 1 | Embedded operation in progress |
| sect_prot_i | input | 8 | Per-sector protection flags |
| start_o | output | 1 | One-cycle start pulse to the engine |
| op_o | output | 2 | Operation: 1 program, 2 chip erase, 3 sector erase |
| op_addr_o | output | 17 | Address captured with the start |
| op_data_o | output | 8 | Data captured with the start |
| rsel_o | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| id_data_o | output | 8 | Identifier/protection byte for the last read |

## Verification
Complete program, chip-erase and sector-erase sequences with random addresses and data show that each operation code, address and data byte reaches the engine once. Sequences with one randomly chosen cycle corrupted, or with F0h inserted between cycles, separate an abort-to-read decoder from one that holds or resumes partial progress. Identifier reads over every sector and over stray offsets and upper address bits confirm that the offset decode and the protection lookup are separate. Bursts of writes while the engine is busy show that writes are ignored rather than queued.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_CHIP = 2'd2,
    OP_SECT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_IDENT  = 2'd1,
    RS_STATUS = 2'd2
  } rsel_e;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PGM_ARM,
    ST_ERS_ARM,
    ST_ERS_UNL1,
    ST_ERS_UNL2,
    ST_AUTOSEL,
    ST_BUSY
  } seq_st_e;

  localparam logic [7:0] CMD_KEY1    = 8'hAA;
  localparam logic [7:0] CMD_KEY2    = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_RESET   = 8'hF0;

endpackage

// File: rtl/fcd_addr_match.sv
`timescale 1ns/1ps
module fcd_addr_match #(
  parameter int AW    = 17,
  parameter int CMP_W = 12
) (
  input  logic [AW-1:0] addr_i,
  output logic          is_key1_o,
  output logic          is_key2_o
);
  localparam logic [CMP_W-1:0] KEY1_ADDR = CMP_W'(12'h555);
  localparam logic [CMP_W-1:0] KEY2_ADDR = CMP_W'(12'h2AA);

  assign is_key1_o = (addr_i[CMP_W-1:0] == KEY1_ADDR);
  assign is_key2_o = (addr_i[CMP_W-1:0] == KEY2_ADDR);
endmodule

// File: rtl/fcd_seq_fsm.sv
`timescale 1ns/1ps
module fcd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          is_key1_i,
  input  logic          is_key2_i,
  input  logic          busy_i,
  output seq_st_e       state_o,
  output logic          start_o,
  output logic [1:0]    op_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o
);
  seq_st_e       st_q, st_d;
  logic          start_q, launch;
  op_e           op_q, op_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  logic [7:0] cmd;
  assign cmd = 8'(wdata_i);

  always_comb begin
    st_d   = st_q;
    launch = 1'b0;
    op_d   = OP_NONE;
    if (st_q == ST_BUSY) begin
      // hold through the start cycle so the engine can raise busy
      if (!busy_i && !start_q) st_d = ST_READ;
    end else if (wr_en_i) begin
      case (st_q)
        ST_READ:
          st_d = (cmd == CMD_KEY1 && is_key1_i) ? ST_UNL1 : ST_READ;
        ST_UNL1:
          st_d = (cmd == CMD_KEY2 && is_key2_i) ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          st_d = ST_READ;
          if (is_key1_i) begin
            case (cmd)
              CMD_PROG:  st_d = ST_PGM_ARM;
              CMD_ERASE: st_d = ST_ERS_ARM;
              CMD_IDENT: st_d = ST_AUTOSEL;
              default:   st_d = ST_READ;
            endcase
          end
        end
        ST_PGM_ARM: begin
          if (cmd == CMD_RESET) begin
            st_d = ST_READ;
          end else begin
            st_d   = ST_BUSY;
            launch = 1'b1;
            op_d   = OP_PROG;
          end
        end
        ST_ERS_ARM:
          st_d = (cmd == CMD_KEY1 && is_key1_i) ? ST_ERS_UNL1 : ST_READ;
        ST_ERS_UNL1:
          st_d = (cmd == CMD_KEY2 && is_key2_i) ? ST_ERS_UNL2 : ST_READ;
        ST_ERS_UNL2: begin
          st_d = ST_READ;
          if (cmd == CMD_CHIP && is_key1_i) begin
            st_d   = ST_BUSY;
            launch = 1'b1;
            op_d   = OP_CHIP;
          end else if (cmd == CMD_SECT) begin
            st_d   = ST_BUSY;
            launch = 1'b1;
            op_d   = OP_SECT;
          end
        end
        ST_AUTOSEL:
          st_d = (cmd == CMD_RESET) ? ST_READ : ST_AUTOSEL;
        default:
          st_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_READ;
      start_q <= 1'b0;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= launch;
      if (launch) begin
        op_q   <= op_d;
        addr_q <= addr_i;
        data_q <= wdata_i;
      end
    end
  end

  assign state_o   = st_q;
  assign start_o   = start_q;
  assign op_o      = op_q;
  assign op_addr_o = addr_q;
  assign op_data_o = data_q;
endmodule

// File: rtl/fcd_id_rom.sv
`timescale 1ns/1ps
module fcd_id_rom #(
  parameter int              AW     = 17,
  parameter int              DW     = 8,
  parameter int              NSECT  = 8,
  parameter int              OFS_W  = 8,
  parameter logic [DW-1:0]   MFR_ID = 8'h01,
  parameter logic [DW-1:0]   DEV_ID = 8'h20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NSECT-1:0] sect_prot_i,
  output logic [DW-1:0]    id_data_o
);
  localparam int SECT_W = $clog2(NSECT);

  logic [OFS_W-1:0]  ofs;
  logic [SECT_W-1:0] sect;
  logic [DW-1:0]     id_d, id_q;

  assign ofs  = addr_i[OFS_W-1:0];
  assign sect = addr_i[AW-1 -: SECT_W];

  always_comb begin
    case (ofs)
      OFS_W'(0): id_d = MFR_ID;
      OFS_W'(1): id_d = DEV_ID;
      OFS_W'(2): id_d = DW'(sect_prot_i[sect]);
      default:   id_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   id_q <= '0;
    else if (rd_i) id_q <= id_d;
  end

  assign id_data_o = id_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int            AW     = 17,
  parameter int            DW     = 8,
  parameter int            NSECT  = 8,
  parameter int            CMP_W  = 12,
  parameter int            OFS_W  = 8,
  parameter logic [DW-1:0] MFR_ID = 8'h01,
  parameter logic [DW-1:0] DEV_ID = 8'h20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             busy_i,
  input  logic [NSECT-1:0] sect_prot_i,
  output logic             start_o,
  output logic [1:0]       op_o,
  output logic [AW-1:0]    op_addr_o,
  output logic [DW-1:0]    op_data_o,
  output logic [1:0]       rsel_o,
  output logic [DW-1:0]    id_data_o
);
  logic    is_key1, is_key2, wr_en;
  seq_st_e state;

  assign wr_en = wr_i && !busy_i;

  fcd_addr_match #(.AW(AW), .CMP_W(CMP_W)) i_match (
    .addr_i    (addr_i),
    .is_key1_o (is_key1),
    .is_key2_o (is_key2)
  );

  fcd_seq_fsm #(.AW(AW), .DW(DW)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .is_key1_i (is_key1),
    .is_key2_i (is_key2),
    .busy_i    (busy_i),
    .state_o   (state),
    .start_o   (start_o),
    .op_o      (op_o),
    .op_addr_o (op_addr_o),
    .op_data_o (op_data_o)
  );

  fcd_id_rom #(
    .AW(AW), .DW(DW), .NSECT(NSECT), .OFS_W(OFS_W),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) i_rom (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .addr_i      (addr_i),
    .sect_prot_i (sect_prot_i),
    .id_data_o   (id_data_o)
  );

  always_comb begin
    if (state == ST_BUSY || busy_i) rsel_o = RS_STATUS;
    else if (state == ST_AUTOSEL)   rsel_o = RS_IDENT;
    else                            rsel_o = RS_ARRAY;
  end
endmodule

// File: rtl/fcd_checker.sv
`timescale 1ns/1ps
module fcd_checker #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [DW-1:0] wdata_i,
  input logic          busy_i,
  input logic          start_o,
  input logic [1:0]    op_o,
  input logic [1:0]    rsel_o
);
  a_r2_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  a_r2_op_moves_with_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(op_o) |-> start_o);

  a_r11_start_shows_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> rsel_o == 2'd2);

  a_r11_busy_shows_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> rsel_o == 2'd2);

  a_r11_busy_blocks_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !start_o);

  a_r1_rsel_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsel_o != 2'd3);

  a_r12_ident_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel_o == 2'd1 && !(wr_i && wdata_i == 8'hF0)) |=> (rsel_o == 2'd1 || busy_i));
endmodule

bind flash_cmd_decoder fcd_checker #(.DW(DW)) i_fcd_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .busy_i  (busy_i),
  .start_o (start_o),
  .op_o    (op_o),
  .rsel_o  (rsel_o)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy_m, force_busy = 1'b0, busy;
  logic [7:0]  prot = 8'b1010_0110;
  logic        start;
  logic [1:0]  op, rsel;
  logic [16:0] op_addr;
  logic [7:0]  op_data, id_data;

  int checks = 0, errors = 0, n_start = 0, eng_len = 4, eng_cnt;

  always #2.5 clk = ~clk;
  assign busy = busy_m | force_busy;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .busy_i(busy), .sect_prot_i(prot), .start_o(start),
    .op_o(op), .op_addr_o(op_addr), .op_data_o(op_data), .rsel_o(rsel),
    .id_data_o(id_data)
  );

  // engine model: busy rises the cycle after start
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 1'b0; eng_cnt <= 0;
    end else if (start) begin
      busy_m <= 1'b1; eng_cnt <= eng_len;
    end else if (eng_cnt > 1) begin
      eng_cnt <= eng_cnt - 1;
    end else begin
      busy_m <= 1'b0; eng_cnt <= 0;
    end
  end

  always @(posedge clk) if (start) n_start++;

  function automatic logic [7:0] id_expect(input logic [16:0] a, input logic [7:0] p);
    case (a[7:0])
      8'h00:   return 8'h01;
      8'h01:   return 8'h20;
      8'h02:   return {7'b0, p[a[16:14]]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cyc(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_cyc(input logic [16:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic unlock();
    wr_cyc(17'h00555, 8'hAA);
    wr_cyc(17'h002AA, 8'h55);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60; i++) begin
      if (!busy && rsel == 2'd0) break;
      @(negedge clk);
    end
  endtask

  task automatic do_program(input logic [16:0] pa, input logic [7:0] pd);
    int n0;
    unlock();
    wr_cyc(17'h00555, 8'hA0);
    n0 = n_start;
    wr_cyc(pa, pd);
    chk(start == 1'b1, "R2 start", int'(start), 1);
    chk(op == 2'd1, "R2 op", int'(op), 1);
    chk(op_addr == pa, "R2 addr", int'(op_addr), int'(pa));
    chk(op_data == pd, "R2 data", int'(op_data), int'(pd));
    chk(rsel == 2'd2, "R11 status at start", int'(rsel), 2);
    @(negedge clk);
    chk(start == 1'b0, "R2 one cycle", int'(start), 0);
    wait_idle();
    chk(n_start == n0 + 1, "R2 single start", n_start, n0 + 1);
    chk(rsel == 2'd0, "R11 back to array", int'(rsel), 0);
  endtask

  task automatic do_erase(input bit sect, input logic [16:0] sa);
    int n0;
    unlock();
    wr_cyc(17'h00555, 8'h80);
    unlock();
    n0 = n_start;
    if (sect) wr_cyc(sa, 8'h30);
    else      wr_cyc(17'h00555, 8'h10);
    chk(start == 1'b1, sect ? "R4 start" : "R3 start", int'(start), 1);
    chk(op == (sect ? 2'd3 : 2'd2), sect ? "R4 op" : "R3 op", int'(op), sect ? 3 : 2);
    if (sect) chk(op_addr == sa, "R4 addr", int'(op_addr), int'(sa));
    wait_idle();
    chk(n_start == n0 + 1, sect ? "R4 single" : "R3 single", n_start, n0 + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    int n0;
    logic [16:0] a;
    logic [7:0]  d;
    seed = $urandom(32'd4242);

    // R1: writes during reset are ignored
    unlock();
    wr_cyc(17'h00555, 8'h90);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rsel == 2'd0, "R1 rsel", int'(rsel), 0);
    chk(start == 1'b0, "R1 start", int'(start), 0);

    do_program(17'h1ABCD, 8'h3C);
    do_erase(1'b0, '0);
    do_erase(1'b1, 17'h14123);

    // R5/R6/R7 identifier mode
    unlock();
    wr_cyc(17'h00555, 8'h90);
    chk(rsel == 2'd1, "R5 ident", int'(rsel), 1);
    rd_cyc(17'h00000);
    chk(id_data == 8'h01, "R6 mfr", int'(id_data), 1);
    rd_cyc(17'h00001);
    chk(id_data == 8'h20, "R6 dev", int'(id_data), 8'h20);
    rd_cyc(17'h00005);
    chk(id_data == 8'h00, "R6 other", int'(id_data), 0);
    rd_cyc(17'h0A300);
    chk(id_data == 8'h01, "R6 upper bits", int'(id_data), 1);
    for (int s = 0; s < 8; s++) begin
      a = {s[2:0], 14'h0002};
      rd_cyc(a);
      chk(id_data == id_expect(a, prot), "R7 prot", int'(id_data), int'(id_expect(a, prot)));
    end
    // R12 persistence
    n0 = n_start;
    wr_cyc(17'h00555, 8'h12);
    unlock();
    wr_cyc(17'h00555, 8'hA0);
    wr_cyc(17'h00100, 8'h77);
    chk(rsel == 2'd1, "R12 held", int'(rsel), 1);
    chk(n_start == n0, "R12 no start", n_start, n0);
    // R8 any-address reset
    wr_cyc(17'h01234, 8'hF0);
    chk(rsel == 2'd0, "R8 reset", int'(rsel), 0);
    // R8 three-cycle reset from identifier mode
    unlock();
    wr_cyc(17'h00555, 8'h90);
    unlock();
    wr_cyc(17'h00555, 8'hF0);
    chk(rsel == 2'd0, "R8 three-cycle", int'(rsel), 0);

    // R13 upper address bits are don't-care
    wr_cyc(17'h1F555, 8'hAA);
    wr_cyc(17'h0A2AA, 8'h55);
    wr_cyc(17'h13555, 8'h90);
    chk(rsel == 2'd1, "R13 match low bits", int'(rsel), 1);
    wr_cyc(17'h00000, 8'hF0);
    wr_cyc(17'h00755, 8'hAA);
    wr_cyc(17'h002AA, 8'h55);
    wr_cyc(17'h00555, 8'h90);
    chk(rsel == 2'd0, "R13 bit 11:0 mismatch", int'(rsel), 0);

    // R9 wrong cycles
    n0 = n_start;
    wr_cyc(17'h00555, 8'hAA);
    wr_cyc(17'h002AA, 8'h56);
    wr_cyc(17'h00555, 8'hA0);
    wr_cyc(17'h00010, 8'h11);
    chk(n_start == n0, "R9 bad data", n_start, n0);
    unlock();
    wr_cyc(17'h002AA, 8'hA0);
    wr_cyc(17'h00010, 8'h11);
    chk(n_start == n0, "R9 bad addr", n_start, n0);
    unlock();
    wr_cyc(17'h00555, 8'h80);
    wr_cyc(17'h00555, 8'hAA);
    wr_cyc(17'h00555, 8'h55);
    wr_cyc(17'h00555, 8'h10);
    chk(n_start == n0, "R9 erase abort", n_start, n0);
    chk(rsel == 2'd0, "R9 array", int'(rsel), 0);

    // R10 reset between cycles
    unlock();
    wr_cyc(17'h00555, 8'hA0);
    wr_cyc(17'h00123, 8'hF0);
    chk(n_start == n0, "R10 cancel program", n_start, n0);
    chk(rsel == 2'd0, "R10 array", int'(rsel), 0);
    unlock();
    wr_cyc(17'h00555, 8'h80);
    wr_cyc(17'h00555, 8'hF0);
    unlock();
    wr_cyc(17'h00555, 8'h10);
    chk(n_start == n0, "R10 cancel erase", n_start, n0);
    do_program(17'h00042, 8'h99);

    // R11 writes while busy
    eng_len = 20;
    unlock();
    wr_cyc(17'h00555, 8'hA0);
    n0 = n_start;
    wr_cyc(17'h00200, 8'h5A);
    unlock();
    wr_cyc(17'h00555, 8'hA0);
    wr_cyc(17'h00300, 8'h6B);
    chk(rsel == 2'd2, "R11 status while busy", int'(rsel), 2);
    wait_idle();
    chk(n_start == n0 + 1, "R11 ignored while busy", n_start, n0 + 1);
    chk(op_addr == 17'h00200, "R11 addr kept", int'(op_addr), 17'h200);
    force_busy = 1'b1;
    unlock();
    wr_cyc(17'h00555, 8'h90);
    force_busy = 1'b0;
    @(negedge clk);
    chk(rsel == 2'd0, "R11 forced busy", int'(rsel), 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int kind;
      kind = int'($urandom % 3);
      eng_len = 2 + int'($urandom % 8);
      a = 17'($urandom);
      d = 8'($urandom);
      if (kind == 0) begin
        if (d == 8'hF0) d = 8'h0F;
        do_program(a, d);
      end else if (kind == 1) begin
        do_erase(1'b1, a);
      end else begin
        int step;
        logic [16:0] sa [3];
        logic [7:0]  sd [3];
        sa[0] = 17'h00555; sd[0] = 8'hAA;
        sa[1] = 17'h002AA; sd[1] = 8'h55;
        sa[2] = 17'h00555; sd[2] = 8'hA0;
        step = int'($urandom % 3);
        sd[step] = sd[step] ^ 8'(1 + ($urandom % 255));
        n0 = n_start;
        for (int k = 0; k < 3; k++) wr_cyc(sa[k], sd[k]);
        wr_cyc(a, d);
        chk(n_start == n0, "R9 random corrupt", n_start, n0);
        wr_cyc(17'h00000, 8'hF0);
        chk(rsel == 2'd0, "R8 random reset", int'(rsel), 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule